// File: doc/BRIEF.md
# Wired Interrupt Aggregator

This block collects events from 32 interrupt lines into one pending word and drives a single wired interrupt towards a parent controller. Each line passes through a two-stage synchroniser. One control bit sets the sensing mode for the whole instance. In level mode a line that is high keeps its pending bit set. In rising-edge mode only a low-to-high transition sets the bit.

Software reaches the block through a small register port with 6-bit byte offsets. Write-only set-cause register (offset 0x08): a one in a bit sets the matching cause bit, which re-triggers that source. Cause register (offset 0x00): writing a zero to a bit clears it. Mask register (offset 0x10): a one masks the source. Control register (offset 0x28): bit 3 selects the sensing mode. Bit 5 is a message-signalled mask flag that is only stored. The wired output is high whenever any unmasked cause bit is set.

Top module: `irq_wire_aggregator`

## Requirements
- R1: After reset the cause register reads 0x00000000, the mask register reads 0xFFFFFFFF, the control register reads 0x00000000, and irq_out is low.
- R2: With control bit 3 at 0 (level mode), a source held high sets its cause bit and sets it again every cycle. A clear write does not remove the bit while the source stays high. The clear takes effect once the source is low.
- R3: With control bit 3 at 1 (rising-edge mode), a 0-to-1 transition of a source sets its cause bit once. After a clear, the bit stays clear while the source remains high, and it sets again only on the next rising transition.
- R4: A write to offset 0x00 clears every cause bit whose write-data bit is 0 and leaves bits whose write-data bit is 1 unchanged.
- R5: A write to offset 0x08 sets every cause bit whose write-data bit is 1. Zero bits have no effect. A read of offset 0x08 returns 0.
- R6: A 1 in mask bit i (offset 0x10) keeps cause bit i from driving irq_out, but the cause bit is still recorded. irq_out is high exactly when some cause bit is set whose mask bit is 0.
- R7: The control register (offset 0x28) stores only bit 3 and bit 5, and all other bits read as 0. Bit 5 has no effect on irq_out.
- R8: When a hardware set and a software clear reach the same cause bit in the same cycle, the bit ends up set.
- R9: A read from any offset other than 0x00, 0x08, 0x10 and 0x28 returns 0, and a write to such an offset changes no register.
- R10: A source change driven just before a clock edge appears in the cause register after the third rising edge (two synchroniser flops and the cause flop).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_src | input | 32 | Interrupt source lines, one per source |
| cfg_we | input | 1 | Register write strobe, one write per cycle |
| cfg_addr | input | 6 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr, combinational |
| irq_out | output | 1 | Combined wired interrupt to the parent controller |

## Verification
Register-level patterns are driven first with all sources quiet: sparse set-cause words followed by partial clear words. These show that a clear acts only on zero bits and a set only on one bits, and that unmapped and write-only offsets read zero. A source held high is then run in both sensing modes, which separates level re-setting from single-shot edge capture. A rising edge is timed so that it lands in the same cycle as a clear-all write, which exposes the set-versus-clear priority. The latency of an input change is checked edge by edge, and the mask and the stored message-signalled flag are toggled around a pending bit to show which of them gates the output.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
  localparam int unsigned ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_CAUSE = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_SETC  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h28;

  localparam int unsigned CTRL_EDGE_BIT = 3;
  localparam int unsigned CTRL_MSIM_BIT = 5;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CAUSE,
    SEL_SETC,
    SEL_MASK,
    SEL_CTRL
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] ofs);
    case (ofs)
      OFS_CAUSE: decode_ofs = SEL_CAUSE;
      OFS_SETC:  decode_ofs = SEL_SETC;
      OFS_MASK:  decode_ofs = SEL_MASK;
      OFS_CTRL:  decode_ofs = SEL_CTRL;
      default:   decode_ofs = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irqa_detect.sv
module irqa_detect #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic            edge_mode,
  output logic [NSRC-1:0] hit
);
  logic [NSRC-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= src;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_sense
    always_comb begin
      if (edge_mode) hit[i] = s2_q[i] & ~prev_q[i];
      else           hit[i] = s2_q[i];
    end
  end

  // R3: in edge mode a held input never produces two hits in a row
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && $past(edge_mode)) |-> ((hit & $past(hit)) == '0));
endmodule

// File: rtl/irqa_cause_bank.sv
module irqa_cause_bank #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] hit,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_keep,
  input  logic            set_we,
  input  logic [NSRC-1:0] set_bits,
  output logic [NSRC-1:0] cause
);
  logic [NSRC-1:0] cause_q, cause_d, sw_set, kept;

  always_comb begin
    sw_set  = set_we ? set_bits : '0;
    kept    = clr_we ? (cause_q & clr_keep) : cause_q;
    cause_d = kept | sw_set | hit;   // any set beats a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_d;
  end

  assign cause = cause_q;

  // R8: a hardware hit always lands, even against a clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((cause_q & $past(hit)) == $past(hit)));

  // R5: a software set always lands
  a_r5_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((cause_q & $past(set_bits)) == $past(set_bits)));

  // R4: cleared bits without a competing set read zero next cycle
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((cause_q & ~$past(clr_keep) & ~$past(hit | sw_set)) == '0));

  // R2: no cause bit appears without a source
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & ~$past(cause_q | sw_set | hit)) == '0));
endmodule

// File: rtl/irq_wire_aggregator.sv
module irq_wire_aggregator
  import irqa_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_src,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [NSRC-1:0]   cfg_wdata,
  output logic [NSRC-1:0]   cfg_rdata,
  output logic              irq_out
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  reg_sel_e        sel;
  logic            wr_cause, wr_setc, wr_mask, wr_ctrl;
  logic [NSRC-1:0] mask_q, mask_d;
  logic            edge_q, edge_d, msim_q, msim_d;
  logic [NSRC-1:0] hit, cause;

  always_comb begin
    sel      = decode_ofs(cfg_addr);
    wr_cause = cfg_we && (sel == SEL_CAUSE);
    wr_setc  = cfg_we && (sel == SEL_SETC);
    wr_mask  = cfg_we && (sel == SEL_MASK);
    wr_ctrl  = cfg_we && (sel == SEL_CTRL);
  end

  always_comb begin
    mask_d = mask_q;
    edge_d = edge_q;
    msim_d = msim_q;
    if (wr_mask) mask_d = cfg_wdata;
    if (wr_ctrl) begin
      edge_d = cfg_wdata[CTRL_EDGE_BIT];
      msim_d = cfg_wdata[CTRL_MSIM_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mask_q <= '1;
      edge_q <= 1'b0;
      msim_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      edge_q <= edge_d;
      msim_q <= msim_d;
    end
  end

  irqa_detect #(.NSRC(NSRC)) u_detect (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .src       (irq_src),
    .edge_mode (edge_q),
    .hit       (hit)
  );

  irqa_cause_bank #(.NSRC(NSRC)) u_cause (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .hit      (hit),
    .clr_we   (wr_cause),
    .clr_keep (cfg_wdata),
    .set_we   (wr_setc),
    .set_bits (cfg_wdata),
    .cause    (cause)
  );

  always_comb begin
    cfg_rdata = '0;
    case (sel)
      SEL_CAUSE: cfg_rdata = cause;
      SEL_MASK:  cfg_rdata = mask_q;
      SEL_CTRL: begin
        cfg_rdata[CTRL_EDGE_BIT] = edge_q;
        cfg_rdata[CTRL_MSIM_BIT] = msim_q;
      end
      default:   cfg_rdata = '0;
    endcase
  end

  assign irq_out = |(cause & ~mask_q);

  // R6: a fully masked instance never raises the wire
  a_r6_all_masked: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mask_q == '1) |-> !irq_out);

  // R9: a write to an unmapped offset leaves mask and control unchanged
  a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && sel == SEL_NONE) |=> ($stable(mask_q) && $stable(edge_q) && $stable(msim_q)));
endmodule

// File: tb/irq_wire_aggregator_tb.sv
module irq_wire_aggregator_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_src;
  logic        cfg_we;
  logic [5:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        irq_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  irq_wire_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_out(irq_out)
  );

  // fields: we[78] addr[77:72] data[71:40] expect[39:8] req[7:0]
  localparam int NV = 17;
  localparam logic [78:0] VEC [0:NV-1] = '{
    {1'b0, 6'h10, 32'h0,        32'hFFFF_FFFF, 8'd1},  // R1 mask
    {1'b0, 6'h00, 32'h0,        32'h0000_0000, 8'd1},  // R1 cause
    {1'b0, 6'h28, 32'h0,        32'h0000_0000, 8'd1},  // R1 control
    {1'b1, 6'h28, 32'hFFFF_FFFF, 32'h0,        8'd7},
    {1'b0, 6'h28, 32'h0,        32'h0000_0028, 8'd7},  // R7 only bits 3,5
    {1'b1, 6'h28, 32'h0,        32'h0,         8'd7},
    {1'b1, 6'h08, 32'h0000_00A5, 32'h0,        8'd5},
    {1'b0, 6'h00, 32'h0,        32'h0000_00A5, 8'd5},  // R5 set
    {1'b1, 6'h00, 32'hFFFF_FF0F, 32'h0,        8'd4},
    {1'b0, 6'h00, 32'h0,        32'h0000_0005, 8'd4},  // R4 partial clear
    {1'b1, 6'h08, 32'h0,        32'h0,         8'd5},
    {1'b0, 6'h00, 32'h0,        32'h0000_0005, 8'd5},  // R5 zero no effect
    {1'b0, 6'h08, 32'h0,        32'h0000_0000, 8'd5},  // R5 reads zero
    {1'b1, 6'h3C, 32'hFFFF_FFFF, 32'h0,        8'd9},
    {1'b0, 6'h3C, 32'h0,        32'h0000_0000, 8'd9},  // R9 unmapped read
    {1'b0, 6'h10, 32'h0,        32'hFFFF_FFFF, 8'd9},  // R9 mask untouched
    {1'b1, 6'h00, 32'h0,        32'h0,         8'd4}   // R4 clear all
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    cfg_addr = a; #2; d = cfg_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; irq_src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] r;
    do_reset();
    check("R1 irq_out", {31'b0, irq_out}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][78]) wr(VEC[i][77:72], VEC[i][71:40]);
      else begin
        rd(VEC[i][77:72], r);
        check($sformatf("R%0d table entry %0d", VEC[i][7:0], i), r, VEC[i][39:8]);
      end
    end

    // R6 masking
    wr(6'h08, 32'h0000_0004);
    rd(6'h00, r); check("R6 masked bit recorded", r, 32'h4);
    check("R6 masked irq low", {31'b0, irq_out}, 32'h0);
    wr(6'h10, 32'hFFFF_FFFB);
    check("R6 unmasked irq high", {31'b0, irq_out}, 32'h1);
    wr(6'h28, 32'h0000_0020);
    check("R7 msi flag no effect", {31'b0, irq_out}, 32'h1);
    wr(6'h00, 32'h0);
    check("R6 irq low after clear", {31'b0, irq_out}, 32'h0);
    wr(6'h28, 32'h0);

    // R2 level mode
    irq_src[7] = 1'b1; settle();
    rd(6'h00, r); check("R2 level sets", r, 32'h80);
    wr(6'h00, 32'h0); @(negedge clk);
    rd(6'h00, r); check("R2 clear ignored while high", r, 32'h80);
    irq_src[7] = 1'b0; settle();
    wr(6'h00, 32'h0);
    rd(6'h00, r); check("R2 clear after low", r, 32'h0);

    // R10 latency
    irq_src[9] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(6'h00, r); check("R10 not yet after two edges", r, 32'h0);
    @(negedge clk);
    rd(6'h00, r); check("R10 present after three edges", r, 32'h200);
    irq_src[9] = 1'b0; settle();
    wr(6'h00, 32'h0);

    // R3 edge mode
    wr(6'h28, 32'h0000_0008);
    irq_src[4] = 1'b1; settle();
    rd(6'h00, r); check("R3 edge sets", r, 32'h10);
    wr(6'h00, 32'h0); settle();
    rd(6'h00, r); check("R3 held high stays clear", r, 32'h0);
    irq_src[4] = 1'b0; settle();
    irq_src[4] = 1'b1; settle();
    rd(6'h00, r); check("R3 new edge sets again", r, 32'h10);

    // R8 set beats clear in the same cycle (edge mode, bit 4 pending)
    irq_src[12] = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(6'h00, 32'h0);   // captured on the edge where the hit lands
    rd(6'h00, r); check("R8 hit wins over clear", r, 32'h1000);

    // R1 reset in mid-run
    do_reset();
    rd(6'h00, r); check("R1 cause after reset", r, 32'h0);
    rd(6'h10, r); check("R1 mask after reset", r, 32'hFFFF_FFFF);
    rd(6'h28, r); check("R1 control after reset", r, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule